// File: doc/BRIEF.md
# Eye Scan Sweep Controller

This block runs a horizontal eye scan on a live recovered data stream without disturbing the data path. It drives one or two exploring sampling phases. Each phase is an 8-bit two's-complement offset from the eye centre in 1/256 UI steps, so the range -128..+127 spans -0.5 UI to +0.5 UI. A start pulse in automatic mode begins a sweep. The controller walks the phases back to zero and pulses the phase and sampling-path resets. For each scan point it then settles the phases, clears the per-phase error accumulators and lets them count for a programmable dwell. At the end of the dwell it presents the totals with a one-cycle strobe. After that it moves on to the next point until the unit interval has been covered.

The parameter `NUM_PH` chooses the variant. With 2, phase 0 sweeps the right half of the eye and phase 1 sweeps the left half at the same time, over 128 points. With 1, a single phase covers the whole eye over 256 points: from 0 down to -128, then from +1 up to +127. With 0, no scan logic is built and all outputs are zero. In manual mode the phase outputs follow user-supplied positions. In every mode a phase output moves by at most one step per clock.

The state machine has six states:
- `S_IDLE`: not busy. Targets are zero in automatic mode and the manual inputs in manual mode. A start in automatic mode moves to `S_CENTER`.
- `S_CENTER`: the phases walk to zero. Once both are at zero it moves to `S_PULSE`.
- `S_PULSE`: issues the one-cycle reset pulse and always moves to `S_STEP`.
- `S_STEP`: targets the current point and clears the accumulators. Once every phase has arrived it moves to `S_DWELL`.
- `S_DWELL`: the accumulators count. After the dwell length it moves to `S_REPORT`.
- `S_REPORT`: raises the valid strobe. It moves to `S_STEP` for the next point, or to `S_IDLE` after the last point.

Top module: `eye_sweep_ctrl`

## Requirements
- R1: After reset, busy is low, both phase outputs are 0, both valid strobes are low and both error counts are 0.
- R2: Start is accepted only in automatic mode (auto_mode=1) while busy is low. Busy is high in the clock after acceptance and stays high until the last point has been reported. A start while busy, or in manual mode, is ignored.
- R3: Before the first point, the phases are walked to 0. Then samp_rst, ph0_rst and, with two phases, ph1_rst are high for exactly one cycle while both phase outputs are 0. This happens once per scan.
- R4: A phase output changes by at most one step (+1 or -1 in 8-bit two's complement) per clock.
- R5: With two phases, point k (k=0..127) puts ph0_pos at +k and ph1_pos at -1-k, so a scan reports 128 points.
- R6: With one phase, the points are 0, -1, ..., -128 and then +1, ..., +127 (256 points). ph1_pos stays 0 and err_vld1 never rises.
- R7: Each point dwells exactly dwell_cycles clock cycles, with 0 treated as 1. The reported count equals the number of dwell cycles in which the phase's err_inc input was high.
- R8: err_vld0/err_vld1 are high for a single cycle per point. In that cycle the count is presented and the phase outputs are unchanged from the previous cycle. The count restarts from 0 for the next point.
- R9: An error count saturates at 2^CNT_W-1 and does not wrap.
- R10: In manual mode each phase output steps one position per clock toward its manual input and then holds it. man_ph1 is used only with two phases.
- R11: When idle in automatic mode, the phase outputs step back to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| auto_mode | input | 1 | 1 = automatic sweep, 0 = manual positioning |
| start | input | 1 | Scan request pulse |
| dwell_cycles | input | 48 | Dwell per point in clock cycles |
| man_ph0 | input | 8 | Manual position for phase 0 |
| man_ph1 | input | 8 | Manual position for phase 1 |
| err_inc0 | input | 1 | Error seen by phase 0 this cycle |
| err_inc1 | input | 1 | Error seen by phase 1 this cycle |
| busy | output | 1 | Scan in progress |
| ph0_pos | output | 8 | Current position of phase 0 |
| ph1_pos | output | 8 | Current position of phase 1 |
| samp_rst | output | 1 | Sampling-path reset pulse |
| ph0_rst | output | 1 | Phase 0 reset pulse |
| ph1_rst | output | 1 | Phase 1 reset pulse |
| err_cnt0 | output | 52 | Accumulated errors of phase 0 |
| err_vld0 | output | 1 | Count strobe for phase 0 |
| err_cnt1 | output | 52 | Accumulated errors of phase 1 |
| err_vld1 | output | 1 | Count strobe for phase 1 |

## Verification
Some rules are checked by assertions on every cycle. These are the one-step slew limit, saturation holding at the maximum, the reset pulse falling only while both phases sit at zero, and the single-cycle valid strobe arriving while busy with the phases still. A further assertion checks that the centring state is entered only from idle. Other behaviour only the bench's scenarios can show: the exact order of points in each variant, the dwell length behind each count, the point total per scan, the start being ignored mid-scan and in manual mode, and the phases returning to zero after a scan. The bench runs a two-phase instance and a one-phase instance with a narrow counter side by side, under random dwells and eye-closure thresholds.

// File: rtl/eye_sweep_pkg.sv
package eye_sweep_pkg;

    localparam int PH_W = 8;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CENTER,
        S_PULSE,
        S_STEP,
        S_DWELL,
        S_REPORT
    } sweep_state_t;

endpackage

// File: rtl/eye_phase_slew.sv
module eye_phase_slew #(
    parameter int PH_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PH_W-1:0] tgt,
    output logic [PH_W-1:0] pos,
    output logic            at_tgt
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos <= '0;
        end else if ($signed(tgt) > $signed(pos)) begin
            pos <= pos + 1'b1;
        end else if ($signed(tgt) < $signed(pos)) begin
            pos <= pos - 1'b1;
        end
    end

    assign at_tgt = (pos == tgt);

    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((pos == $past(pos)) || (pos == $past(pos) + 1'b1) || (pos == $past(pos) - 1'b1))); // R4

endmodule

// File: rtl/eye_err_accum.sv
module eye_err_accum #(
    parameter int CNT_W = 52
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (en && inc && (cnt != CNT_MAX)) begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt == CNT_MAX) && !clr) |=> (cnt == CNT_MAX)); // R9

endmodule

// File: rtl/eye_sweep_fsm.sv
module eye_sweep_fsm
    import eye_sweep_pkg::*;
#(
    parameter int NUM_PH  = 2,
    parameter int DWELL_W = 48
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               auto_mode,
    input  logic               start,
    input  logic [DWELL_W-1:0] dwell_cycles,
    input  logic [PH_W-1:0]    man_ph0,
    input  logic [PH_W-1:0]    man_ph1,
    input  logic               all_at_tgt,
    input  logic               all_at_zero,
    output logic               busy,
    output logic [PH_W-1:0]    tgt0,
    output logic [PH_W-1:0]    tgt1,
    output logic               rst_pulse,
    output logic               acc_clr,
    output logic               acc_en,
    output logic               vld
);

    localparam int NPTS = (NUM_PH == 2) ? 128 : 256;
    localparam logic [7:0] LAST_K = 8'(NPTS - 1);

    sweep_state_t state, nxt;
    logic [7:0]         k;
    logic [DWELL_W-1:0] dcnt;
    logic               dwell_last;
    logic [PH_W-1:0]    pt0, pt1;

    assign dwell_last = ({1'b0, dcnt} + 1'b1) >= {1'b0, dwell_cycles};

    generate
        if (NUM_PH == 2) begin : g_two
            assign pt0 = k;
            assign pt1 = 8'hFF - k;
        end else begin : g_one
            assign pt0 = (k <= 8'd128) ? (8'd0 - k) : (k - 8'd128);
            assign pt1 = '0;
        end
    endgenerate

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   if (start && auto_mode) nxt = S_CENTER;
            S_CENTER: if (all_at_zero) nxt = S_PULSE;
            S_PULSE:  nxt = S_STEP;
            S_STEP:   if (all_at_tgt) nxt = S_DWELL;
            S_DWELL:  if (dwell_last) nxt = S_REPORT;
            S_REPORT: nxt = (k == LAST_K) ? S_IDLE : S_STEP;
            default:  nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            k     <= '0;
            dcnt  <= '0;
        end else begin
            state <= nxt;
            if (state == S_PULSE)  k <= '0;
            if (state == S_REPORT) k <= k + 1'b1;
            if (state == S_STEP)   dcnt <= '0;
            else if (state == S_DWELL) dcnt <= dcnt + 1'b1;
        end
    end

    always_comb begin
        busy      = (state != S_IDLE);
        rst_pulse = (state == S_PULSE);
        acc_clr   = (state == S_STEP) || (state == S_PULSE);
        acc_en    = (state == S_DWELL);
        vld       = (state == S_REPORT);
        unique case (state)
            S_IDLE: begin
                tgt0 = auto_mode ? '0 : man_ph0;
                tgt1 = (auto_mode || NUM_PH != 2) ? '0 : man_ph1;
            end
            S_CENTER, S_PULSE: begin
                tgt0 = '0;
                tgt1 = '0;
            end
            default: begin
                tgt0 = pt0;
                tgt1 = pt1;
            end
        endcase
    end

    AST_CENTER_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        ((state != S_IDLE) && (state != S_CENTER)) |=> (state != S_CENTER)); // R2

    AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        vld |=> !vld); // R8

endmodule

// File: rtl/eye_sweep_ctrl.sv
module eye_sweep_ctrl
    import eye_sweep_pkg::*;
#(
    parameter int NUM_PH  = 2,
    parameter int DWELL_W = 48,
    parameter int CNT_W   = 52
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               auto_mode,
    input  logic               start,
    input  logic [DWELL_W-1:0] dwell_cycles,
    input  logic [PH_W-1:0]    man_ph0,
    input  logic [PH_W-1:0]    man_ph1,
    input  logic               err_inc0,
    input  logic               err_inc1,
    output logic               busy,
    output logic [PH_W-1:0]    ph0_pos,
    output logic [PH_W-1:0]    ph1_pos,
    output logic               samp_rst,
    output logic               ph0_rst,
    output logic               ph1_rst,
    output logic [CNT_W-1:0]   err_cnt0,
    output logic               err_vld0,
    output logic [CNT_W-1:0]   err_cnt1,
    output logic               err_vld1
);

    generate
        if (NUM_PH == 0) begin : g_none
            assign busy     = 1'b0;
            assign ph0_pos  = '0;
            assign ph1_pos  = '0;
            assign samp_rst = 1'b0;
            assign ph0_rst  = 1'b0;
            assign ph1_rst  = 1'b0;
            assign err_cnt0 = '0;
            assign err_vld0 = 1'b0;
            assign err_cnt1 = '0;
            assign err_vld1 = 1'b0;
        end else begin : g_scan
            logic [PH_W-1:0]  tgt_a [2];
            logic [PH_W-1:0]  pos_a [2];
            logic             at_a  [2];
            logic [CNT_W-1:0] cnt_a [2];
            logic             inc_a [2];
            logic             rst_pulse, acc_clr, acc_en, vld;

            assign inc_a[0] = err_inc0;
            assign inc_a[1] = err_inc1;

            eye_sweep_fsm #(.NUM_PH(NUM_PH), .DWELL_W(DWELL_W)) u_fsm (
                .clk          (clk),
                .rst_n        (rst_n),
                .auto_mode    (auto_mode),
                .start        (start),
                .dwell_cycles (dwell_cycles),
                .man_ph0      (man_ph0),
                .man_ph1      (man_ph1),
                .all_at_tgt   (at_a[0] && at_a[1]),
                .all_at_zero  ((pos_a[0] == '0) && (pos_a[1] == '0)),
                .busy         (busy),
                .tgt0         (tgt_a[0]),
                .tgt1         (tgt_a[1]),
                .rst_pulse    (rst_pulse),
                .acc_clr      (acc_clr),
                .acc_en       (acc_en),
                .vld          (vld)
            );

            for (genvar g = 0; g < 2; g++) begin : g_ph
                if (g < NUM_PH) begin : g_live
                    eye_phase_slew #(.PH_W(PH_W)) u_slew (
                        .clk    (clk),
                        .rst_n  (rst_n),
                        .tgt    (tgt_a[g]),
                        .pos    (pos_a[g]),
                        .at_tgt (at_a[g])
                    );
                    eye_err_accum #(.CNT_W(CNT_W)) u_acc (
                        .clk   (clk),
                        .rst_n (rst_n),
                        .clr   (acc_clr),
                        .en    (acc_en),
                        .inc   (inc_a[g]),
                        .cnt   (cnt_a[g])
                    );
                end else begin : g_off
                    assign pos_a[g] = '0;
                    assign at_a[g]  = 1'b1;
                    assign cnt_a[g] = '0;
                end
            end

            assign ph0_pos  = pos_a[0];
            assign ph1_pos  = pos_a[1];
            assign err_cnt0 = cnt_a[0];
            assign err_cnt1 = cnt_a[1];
            assign err_vld0 = vld;
            assign err_vld1 = vld && (NUM_PH == 2);
            assign samp_rst = rst_pulse;
            assign ph0_rst  = rst_pulse;
            assign ph1_rst  = rst_pulse && (NUM_PH == 2);

            AST_PULSE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                samp_rst |-> ((ph0_pos == '0) && (ph1_pos == '0))); // R3

            AST_VLD_STILL: assert property (@(posedge clk) disable iff (!rst_n)
                err_vld0 |-> ($stable(ph0_pos) && $stable(ph1_pos))); // R8

            AST_VLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
                err_vld0 |-> busy); // R2
        end
    endgenerate

endmodule

// File: tb/eye_sweep_ctrl_test.sv
module eye_sweep_ctrl_test;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n, auto_mode, start;
    logic [47:0] dwell_cycles;
    logic [7:0]  man_ph0, man_ph1;

    logic        busy_a, samp_a, r0_a, r1_a, vld0_a, vld1_a;
    logic [7:0]  ph0_a, ph1_a;
    logic [51:0] cnt0_a, cnt1_a;
    logic        inc0_a, inc1_a;

    logic        busy_b, samp_b, r0_b, r1_b, vld0_b, vld1_b;
    logic [7:0]  ph0_b, ph1_b;
    logic [3:0]  cnt0_b, cnt1_b;
    logic        inc0_b, inc1_b;

    int checks = 0, errors = 0;
    int thr0 = 64, thr1 = 64;
    int cur_dwell = 4;
    int k_a = 0, k_b = 0, pa = 0, pb = 0, v1b = 0, slew_bad = 0;
    int prev0a = 0, prev1a = 0, prev0b = 0;

    function automatic bit is_bad(int p, int thr);
        return ((p < 0) ? -p : p) >= thr;
    endfunction

    function automatic longint exp_cnt(int p, int thr, int d, longint mx);
        longint n;
        n = (d == 0) ? 1 : d;
        if (!is_bad(p, thr)) return 0;
        return (n > mx) ? mx : n;
    endfunction

    function automatic int pt0(int nph, int k);
        if (nph == 2) return k;
        return (k <= 128) ? -k : k - 128;
    endfunction

    assign inc0_a = is_bad(int'($signed(ph0_a)), thr0);
    assign inc1_a = is_bad(int'($signed(ph1_a)), thr1);
    assign inc0_b = is_bad(int'($signed(ph0_b)), thr0);
    assign inc1_b = is_bad(int'($signed(ph1_b)), thr1);

    eye_sweep_ctrl #(.NUM_PH(2), .DWELL_W(48), .CNT_W(52)) uut (
        .clk(clk), .rst_n(rst_n), .auto_mode(auto_mode), .start(start),
        .dwell_cycles(dwell_cycles), .man_ph0(man_ph0), .man_ph1(man_ph1),
        .err_inc0(inc0_a), .err_inc1(inc1_a), .busy(busy_a),
        .ph0_pos(ph0_a), .ph1_pos(ph1_a), .samp_rst(samp_a), .ph0_rst(r0_a),
        .ph1_rst(r1_a), .err_cnt0(cnt0_a), .err_vld0(vld0_a),
        .err_cnt1(cnt1_a), .err_vld1(vld1_a)
    );

    eye_sweep_ctrl #(.NUM_PH(1), .DWELL_W(48), .CNT_W(4)) uut_one (
        .clk(clk), .rst_n(rst_n), .auto_mode(auto_mode), .start(start),
        .dwell_cycles(dwell_cycles), .man_ph0(man_ph0), .man_ph1(man_ph1),
        .err_inc0(inc0_b), .err_inc1(inc1_b), .busy(busy_b),
        .ph0_pos(ph0_b), .ph1_pos(ph1_b), .samp_rst(samp_b), .ph0_rst(r0_b),
        .ph1_rst(r1_b), .err_cnt0(cnt0_b), .err_vld0(vld0_b),
        .err_cnt1(cnt1_b), .err_vld1(vld1_b)
    );

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Scoreboard, sampled away from the rising edge
    always @(negedge clk) begin
        if (rst_n) begin
            int c0a, c1a, c0b;
            c0a = int'($signed(ph0_a));
            c1a = int'($signed(ph1_a));
            c0b = int'($signed(ph0_b));
            if ((c0a - prev0a > 1) || (prev0a - c0a > 1) ||
                (c1a - prev1a > 1) || (prev1a - c1a > 1) ||
                (c0b - prev0b > 1) || (prev0b - c0b > 1)) slew_bad++;
            prev0a = c0a; prev1a = c1a; prev0b = c0b;
            if (samp_a) begin
                pa++;
                chk((c0a == 0) && (c1a == 0) && r0_a && r1_a, "R3", "pulse at zero (two-phase)", c0a, 0);
            end
            if (samp_b) begin
                pb++;
                chk((c0b == 0) && r0_b && !r1_b, "R3", "pulse at zero (one-phase)", c0b, 0);
            end
            if (vld0_a) begin
                chk(c0a == pt0(2, k_a), "R5", "phase 0 point", c0a, pt0(2, k_a));
                chk(c1a == -1 - k_a, "R5", "phase 1 point", c1a, -1 - k_a);
                chk(longint'(cnt0_a) == exp_cnt(c0a, thr0, cur_dwell, 64'hF_FFFF_FFFF_FFFF),
                    "R7", "phase 0 count", longint'(cnt0_a), exp_cnt(c0a, thr0, cur_dwell, 64'hF_FFFF_FFFF_FFFF));
                chk(longint'(cnt1_a) == exp_cnt(c1a, thr1, cur_dwell, 64'hF_FFFF_FFFF_FFFF),
                    "R7", "phase 1 count", longint'(cnt1_a), exp_cnt(c1a, thr1, cur_dwell, 64'hF_FFFF_FFFF_FFFF));
                chk(vld1_a, "R8", "phase 1 strobe with phase 0", longint'(vld1_a), 1);
                k_a++;
            end
            if (vld0_b) begin
                chk(c0b == pt0(1, k_b), "R6", "single phase point", c0b, pt0(1, k_b));
                chk(longint'(cnt0_b) == exp_cnt(c0b, thr0, cur_dwell, 15),
                    "R9", "saturating count", longint'(cnt0_b), exp_cnt(c0b, thr0, cur_dwell, 15));
                k_b++;
            end
            if (vld1_b) v1b++;
        end
    end

    task automatic run_scan(int d, int t0, int t1);
        cur_dwell = d;
        thr0 = t0; thr1 = t1;
        k_a = 0; k_b = 0; pa = 0; pb = 0;
        @(negedge clk);
        dwell_cycles = 48'(d);
        auto_mode = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy_a && busy_b, "R2", "busy after start", longint'(busy_a), 1);
        repeat (60) @(negedge clk);
        start = 1'b1;                  // ignored: scan already running
        @(negedge clk);
        start = 1'b0;
        while (busy_a || busy_b) @(negedge clk);
        chk(k_a == 128, "R5", "two-phase point total", k_a, 128);
        chk(k_b == 256, "R6", "one-phase point total", k_b, 256);
        chk(pa == 1 && pb == 1, "R3", "reset pulses per scan", pa + pb, 2);
        chk(!busy_a && !busy_b, "R2", "busy low after last point", longint'(busy_a | busy_b), 0);
        repeat (140) @(negedge clk);
        chk(ph0_a == 8'd0 && ph1_a == 8'd0 && ph0_b == 8'd0, "R11", "phases back at zero",
            longint'($signed(ph0_b)), 0);
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 190000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1729));
        rst_n = 1'b0; auto_mode = 1'b1; start = 1'b0;
        dwell_cycles = 48'd4; man_ph0 = 8'd0; man_ph1 = 8'd0;
        repeat (5) @(negedge clk);
        chk(!busy_a && ph0_a == 0 && ph1_a == 0 && !vld0_a && !vld1_a && cnt0_a == 0 && cnt1_a == 0,
            "R1", "reset state", longint'(busy_a), 0);
        rst_n = 1'b1;

        // Manual mode, slew limited
        auto_mode = 1'b0; man_ph0 = 8'd20; man_ph1 = 8'hFB;
        @(negedge clk);
        chk(ph0_a == 8'd1 && ph1_a == 8'hFF, "R10", "first manual step", longint'($signed(ph0_a)), 1);
        repeat (25) @(negedge clk);
        chk(ph0_a == 8'd20, "R10", "manual phase 0 reached", longint'($signed(ph0_a)), 20);
        chk(ph1_a == 8'hFB, "R10", "manual phase 1 reached", longint'($signed(ph1_a)), -5);
        chk(ph0_b == 8'd20 && ph1_b == 8'd0, "R6", "one-phase ignores man_ph1", longint'($signed(ph1_b)), 0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk(!busy_a && !busy_b, "R2", "start ignored in manual mode", longint'(busy_a), 0);
        man_ph0 = 8'(int'($urandom_range(120)) - 60);
        repeat (130) @(negedge clk);
        chk(ph0_a == man_ph0, "R10", "manual random target", longint'($signed(ph0_a)), longint'($signed(man_ph0)));

        // Directed scans: dwell 0 treated as 1, then saturating dwell; start while off-centre
        run_scan(0, 100, 30);
        run_scan(17, 50, 90);
        for (int i = 0; i < 3; i++) begin
            run_scan(int'($urandom_range(24, 1)), int'($urandom_range(120, 20)), int'($urandom_range(120, 20)));
        end

        chk(v1b == 0, "R6", "no phase 1 strobe in one-phase mode", v1b, 0);
        chk(slew_bad == 0, "R4", "one step per clock", slew_bad, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule